// File: doc/BRIEF.md
# DMA Global Control Registers

This block is the shared register file of a multi-channel DMA engine that supports up to 32 channels. It decodes a small 32-bit read/write register bus, holds the controller-wide enable, and keeps two sticky error summaries that any channel can raise: one for address faults and one for halts. It also gathers the channels' interrupt requests into one pending vector and one interrupt line.

Two per-channel control vectors leave the block. The first is a set of one-cycle doorbell pulses, each of which tells one channel to fetch its first descriptor. The second is a set of level clock enables. Software can change the clock enables by a plain write, or through separate set and clear alias addresses, so that one channel can be touched without a read-modify-write. The channel datapaths sit outside this block. Their per-channel register windows follow at a stride of 0x20 per channel index, so every offset from 0x1C upward is undefined here.

Top module: `dma_glb_regs`

## Requirements
- R1: After reset every register reads zero, and `ctrl_enable`, `irq`, `doorbell` and `clk_en` are all low.
- R2: Bit 0 of the control register (offset 0x00) is the controller enable. A write loads it, it drives `ctrl_enable`, and it reads back at bit 0.
- R3: Bit 2 of the control register is the address-fault summary and bit 3 is the halt summary. A pulse on any `ch_addr_err` or `ch_halt` bit sets the matching summary. The summary stays set until a control write carries a 0 at that bit. A control write with a 1 there leaves the summary unchanged, so software can never set it. All other control bits read zero.
- R4: Offset 0x04 holds one pending bit per channel. A one-cycle pulse on `ch_irq[n]` sets bit n. Writing a 1 to bit n clears it, and writing a 0 leaves it alone. If a channel pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: `irq` is high whenever the enable bit is set and at least one pending bit is set. It goes high the cycle after the pulse that sets a pending bit.
- R6: Writing a 1 to bit n at offset 0x08 or at offset 0x0C raises `doorbell[n]` for exactly the one cycle after the write. Zero bits produce no pulse, and both offsets read as zero.
- R7: A write to offset 0x10 loads the clock-enable vector, which drives `clk_en` and reads back at 0x10.
- R8: Writing a 1 to bit n at offset 0x14 sets `clk_en[n]`, and writing a 1 to bit n at offset 0x18 clears it. Every other bit keeps its value, and both alias offsets read as zero.
- R9: Read data appears on `rdata` in the cycle after `rd_en`. Undefined offsets read zero, and writes to them change nothing. Write-data bits at or above the channel count are dropped, and those bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| ch_irq | input | NUM_CH | Per-channel interrupt request pulses |
| ch_halt | input | NUM_CH | Per-channel halt pulses |
| ch_addr_err | input | NUM_CH | Per-channel address-fault pulses |
| ctrl_enable | output | 1 | Controller enable bit |
| irq | output | 1 | Combined interrupt line |
| doorbell | output | NUM_CH | One-cycle descriptor-fetch pulses |
| clk_en | output | NUM_CH | Per-channel clock enables |

## Verification
Every register update lands on the clock edge that samples the write strobe or the channel pulse. The result shows on the outputs during the following cycle. A doorbell bit is high only in that one following cycle, and it must be low again one cycle later. Read data is registered, so it is valid in the cycle after `rd_en`. The bench drives every stimulus on a falling edge and samples on the next falling edge, which lands each check exactly in the cycle its result is due. For doorbells it samples one more falling edge later to confirm the pulse has ended.

// File: rtl/dma_glb_pkg.sv
`timescale 1ns/1ps
package dma_glb_pkg;

  // Register byte offsets inside the global window
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_PEND   = 'h04;
  localparam int OFS_DB     = 'h08;
  localparam int OFS_DBSET  = 'h0C;
  localparam int OFS_CE     = 'h10;
  localparam int OFS_CESET  = 'h14;
  localparam int OFS_CECLR  = 'h18;

  // Control register bit positions
  localparam int BIT_EN  = 0;
  localparam int BIT_AR  = 2;
  localparam int BIT_HLT = 3;

  typedef struct packed {
    logic ctrl;
    logic pend;
    logic db;
    logic dbset;
    logic ce;
    logic ceset;
    logic ceclr;
  } reg_hit_t;

  // Sticky summary: software may only clear, hardware event sets
  function automatic logic sticky_next(input logic q, input logic wr,
                                       input logic wbit, input logic hw);
    return ((wr ? (q & wbit) : q) | hw);
  endfunction

  function automatic logic [31:0] ctrl_word(input logic en, input logic ar,
                                            input logic hlt);
    logic [31:0] w;
    w = '0;
    w[BIT_EN]  = en;
    w[BIT_AR]  = ar;
    w[BIT_HLT] = hlt;
    return w;
  endfunction

endpackage

// File: rtl/dma_glb_decode.sv
`timescale 1ns/1ps
module dma_glb_decode
  import dma_glb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);

  always_comb begin
    hit.ctrl  = (addr == ADDR_W'(OFS_CTRL));
    hit.pend  = (addr == ADDR_W'(OFS_PEND));
    hit.db    = (addr == ADDR_W'(OFS_DB));
    hit.dbset = (addr == ADDR_W'(OFS_DBSET));
    hit.ce    = (addr == ADDR_W'(OFS_CE));
    hit.ceset = (addr == ADDR_W'(OFS_CESET));
    hit.ceclr = (addr == ADDR_W'(OFS_CECLR));
  end

endmodule

// File: rtl/dma_glb_chvec.sv
`timescale 1ns/1ps
module dma_glb_chvec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] vec_next(input logic [W-1:0] cur,
      input logic ld, input logic [W-1:0] lv, input logic [W-1:0] s,
      input logic [W-1:0] c, input logic [W-1:0] h);
    logic [W-1:0] base;
    base = ld ? lv : cur;
    return (((base | s) & ~c) | h);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= vec_next(q, load, load_val, set_mask, clr_mask, hw_set);
  end

  // A hardware set always lands, even against a same-cycle clear
  assert_hw_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));

  // Clear-mask bits not also hardware-set are low afterwards
  assert_clear_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((q & $past(clr_mask & ~hw_set)) == '0));

  // No update request leaves the vector untouched
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && set_mask == '0 && clr_mask == '0 && hw_set == '0) |=> $stable(q));

endmodule

// File: rtl/dma_glb_ctrl.sv
`timescale 1ns/1ps
module dma_glb_ctrl
  import dma_glb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic w_en,
  input  logic w_ar,
  input  logic w_hlt,
  input  logic any_ar,
  input  logic any_hlt,
  output logic en,
  output logic sum_ar,
  output logic sum_hlt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      sum_ar  <= 1'b0;
      sum_hlt <= 1'b0;
    end else begin
      if (wr) en <= w_en;
      sum_ar  <= sticky_next(sum_ar,  wr, w_ar,  any_ar);
      sum_hlt <= sticky_next(sum_hlt, wr, w_hlt, any_hlt);
    end
  end

  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en));

  assert_ar_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_ar && !wr) |=> sum_ar);

  assert_hlt_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_hlt |=> sum_hlt);

  assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sum_ar && !any_ar) |=> !sum_ar);

endmodule

// File: rtl/dma_glb_regs.sv
`timescale 1ns/1ps
module dma_glb_regs
  import dma_glb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NUM_CH-1:0] ch_irq,
  input  logic [NUM_CH-1:0] ch_halt,
  input  logic [NUM_CH-1:0] ch_addr_err,
  output logic              ctrl_enable,
  output logic              irq,
  output logic [NUM_CH-1:0] doorbell,
  output logic [NUM_CH-1:0] clk_en
);

  localparam logic [NUM_CH-1:0] NONE = '0;

  reg_hit_t          hit;
  logic              wr_ctrl, wr_pend, wr_bell, wr_ce, wr_ceset, wr_ceclr;
  logic              hit_any;
  logic [NUM_CH-1:0] wmask, pend, pend_clr, ce_set, ce_clr;
  logic              sum_ar, sum_hlt;
  logic [31:0]       rd_val;
  logic              unused_wdata;

  dma_glb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .hit  (hit)
  );

  assign hit_any  = |hit;
  assign wmask    = wdata[NUM_CH-1:0];
  assign wr_ctrl  = wr_en & hit.ctrl;
  assign wr_pend  = wr_en & hit.pend;
  assign wr_bell  = wr_en & (hit.db | hit.dbset);
  assign wr_ce    = wr_en & hit.ce;
  assign wr_ceset = wr_en & hit.ceset;
  assign wr_ceclr = wr_en & hit.ceclr;
  assign pend_clr = wr_pend  ? wmask : NONE;
  assign ce_set   = wr_ceset ? wmask : NONE;
  assign ce_clr   = wr_ceclr ? wmask : NONE;
  assign unused_wdata = ^wdata;

  dma_glb_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_ctrl),
    .w_en    (wdata[BIT_EN]),
    .w_ar    (wdata[BIT_AR]),
    .w_hlt   (wdata[BIT_HLT]),
    .any_ar  (|ch_addr_err),
    .any_hlt (|ch_halt),
    .en      (ctrl_enable),
    .sum_ar  (sum_ar),
    .sum_hlt (sum_hlt)
  );

  // Pending vector: write-one-to-clear, channel pulse sets
  dma_glb_chvec #(.W(NUM_CH)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (1'b0),
    .load_val (NONE),
    .set_mask (NONE),
    .clr_mask (pend_clr),
    .hw_set   (ch_irq),
    .q        (pend)
  );

  // Clock enables: direct load plus set/clear aliases
  dma_glb_chvec #(.W(NUM_CH)) u_clken (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_ce),
    .load_val (wmask),
    .set_mask (ce_set),
    .clr_mask (ce_clr),
    .hw_set   (NONE),
    .q        (clk_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) doorbell <= '0;
    else        doorbell <= wr_bell ? wmask : NONE;
  end

  assign irq = ctrl_enable & (|pend);

  always_comb begin
    rd_val = '0;
    if (hit.ctrl)      rd_val = ctrl_word(ctrl_enable, sum_ar, sum_hlt);
    else if (hit.pend) rd_val = 32'(pend);
    else if (hit.ce)   rd_val = 32'(clk_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_val : 32'd0;
  end

  assert_bell_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bell |=> (doorbell == NONE));

  assert_irq_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ch_irq) && ctrl_enable && !wr_ctrl) |=> irq);

  assert_undef_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_any) |=> (rdata == 32'd0));

  assert_undef_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_any) |=> $stable(clk_en));

endmodule

// File: tb/dma_glb_regs_tb.sv
`timescale 1ns/1ps
module dma_glb_regs_tb;

  localparam int NCH = 8;
  localparam logic [31:0] CHMASK = 32'h0000_00FF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCH-1:0]  ch_irq = '0, ch_halt = '0, ch_addr_err = '0;
  logic            ctrl_enable, irq;
  logic [NCH-1:0]  doorbell, clk_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dma_glb_regs #(.NUM_CH(NCH), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_irq(ch_irq), .ch_halt(ch_halt),
    .ch_addr_err(ch_addr_err), .ctrl_enable(ctrl_enable), .irq(irq),
    .doorbell(doorbell), .clk_en(clk_en)
  );

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Returns at the falling edge just after the write edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic chan_pulse(input logic [NCH-1:0] iv, input logic [NCH-1:0] hv,
                            input logic [NCH-1:0] ev);
    @(negedge clk);
    ch_irq = iv; ch_halt = hv; ch_addr_err = ev;
    @(negedge clk);
    ch_irq = '0; ch_halt = '0; ch_addr_err = '0;
  endtask

  function automatic logic [31:0] ctrl_exp(input logic en, input logic ar,
                                           input logic hl);
    return {28'd0, hl, ar, 1'b0, en};
  endfunction

  initial begin
    logic [31:0] rd;
    logic [31:0] m_ce;
    logic [31:0] m_pend;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ctrl_enable", 32'(ctrl_enable), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 doorbell", 32'(doorbell), 0);
    check("R1 clk_en", 32'(clk_en), 0);
    for (int o = 0; o < 7; o++) begin
      bus_rd(8'(o * 4), rd);
      check("R1 readback", rd, 0);
    end

    // R2/R3: enable bit, summaries not settable by software
    bus_wr(8'h00, 32'hFFFF_FFFF);
    check("R2 ctrl_enable", 32'(ctrl_enable), 1);
    bus_rd(8'h00, rd);
    check("R2 R3 ctrl readback", rd, ctrl_exp(1, 0, 0));

    // R3: sticky summaries
    chan_pulse('0, 8'h04, '0);
    bus_rd(8'h00, rd);
    check("R3 halt summary", rd, ctrl_exp(1, 0, 1));
    chan_pulse('0, '0, 8'h80);
    repeat (5) @(negedge clk);
    bus_rd(8'h00, rd);
    check("R3 both summaries held", rd, ctrl_exp(1, 1, 1));
    bus_wr(8'h00, 32'h0000_000D);
    bus_rd(8'h00, rd);
    check("R3 write ones keeps", rd, ctrl_exp(1, 1, 1));
    bus_wr(8'h00, 32'h0000_0005);
    bus_rd(8'h00, rd);
    check("R3 halt cleared", rd, ctrl_exp(1, 1, 0));
    bus_wr(8'h00, 32'h0000_0001);
    bus_rd(8'h00, rd);
    check("R3 fault cleared", rd, ctrl_exp(1, 0, 0));

    // R4/R5: pending per channel
    for (int i = 0; i < NCH; i++) begin
      chan_pulse(NCH'(1 << i), '0, '0);
      check("R5 irq after pulse", 32'(irq), 1);
      bus_rd(8'h04, rd);
      check("R4 pending set", rd, 32'(1 << i));
      bus_wr(8'h04, 32'hFFFF_FF00 | (~(32'(1 << i)) & CHMASK));
      bus_rd(8'h04, rd);
      check("R4 zero bits no effect", rd, 32'(1 << i));
      bus_wr(8'h04, 32'(1 << i));
      check("R5 irq low after clear", 32'(irq), 0);
      bus_rd(8'h04, rd);
      check("R4 pending cleared", rd, 0);
    end

    // R5: enable gates the line
    chan_pulse(8'h22, '0, '0);
    bus_wr(8'h00, 32'h0);
    check("R5 irq gated off", 32'(irq), 0);
    bus_rd(8'h04, rd);
    check("R4 pending kept while disabled", rd, 32'h22);
    bus_wr(8'h00, 32'h1);
    check("R5 irq back on", 32'(irq), 1);

    // R4: set wins over same-cycle clear
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h04; wdata = 32'h0000_002A; ch_irq = 8'h08;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; ch_irq = '0;
    bus_rd(8'h04, rd);
    check("R4 set wins over clear", rd, 32'h08);
    bus_wr(8'h04, 32'hFF);
    check("R5 irq low all cleared", 32'(irq), 0);

    // R6: doorbell sweep over both offsets
    for (int p = 0; p < 256; p++) begin
      bus_wr(p[0] ? 8'h0C : 8'h08, {24'hC3C3C3, 8'(p)});
      check("R6 doorbell pulse", 32'(doorbell), 32'(p));
      @(negedge clk);
      check("R6 doorbell one cycle", 32'(doorbell), 0);
    end
    bus_rd(8'h08, rd);
    check("R6 doorbell reads zero", rd, 0);
    bus_rd(8'h0C, rd);
    check("R6 doorbell set reads zero", rd, 0);

    // R7/R8: clock enable sweep
    m_ce = 0;
    for (int p = 0; p < 256; p++) begin
      logic [31:0] c;
      bus_wr(8'h14, {24'hA5A5A5, 8'(p)});
      m_ce = m_ce | 32'(p);
      check("R8 clk set alias", 32'(clk_en), m_ce);
      c = ((p * 73) + 11) & 255;
      bus_wr(8'h18, {24'h5A5A5A, 8'(c)});
      m_ce = m_ce & ~c;
      check("R8 clk clear alias", 32'(clk_en), m_ce);
      if ((p % 16) == 0) begin
        m_ce = (p * 29 + 3) & 255;
        bus_wr(8'h10, 32'hFFFF_FF00 | m_ce);
        check("R7 clk direct load", 32'(clk_en), m_ce);
        bus_rd(8'h10, rd);
        check("R7 R9 clk readback", rd, m_ce);
      end
    end
    bus_rd(8'h14, rd);
    check("R8 set alias reads zero", rd, 0);
    bus_rd(8'h18, rd);
    check("R8 clear alias reads zero", rd, 0);

    // R9: undefined offsets
    bus_wr(8'h10, 32'h0000_005A);
    m_ce = 32'h5A;
    chan_pulse(8'h11, '0, '0);
    m_pend = 32'h11;
    bus_wr(8'h1C, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'h0000_0000);
    bus_wr(8'h02, 32'hFFFF_FFFF);
    bus_wr(8'hF4, 32'hFFFF_FFFF);
    check("R9 undefined write clk_en", 32'(clk_en), m_ce);
    bus_rd(8'h04, rd);
    check("R9 undefined write pending", rd, m_pend);
    bus_rd(8'h00, rd);
    check("R9 undefined write ctrl", rd, ctrl_exp(1, 0, 0));
    bus_rd(8'h1C, rd);
    check("R9 undefined read 0x1C", rd, 0);
    bus_rd(8'h24, rd);
    check("R9 undefined read 0x24", rd, 0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, rd);
    check("R9 bits above channels dropped", rd, CHMASK);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule